// File: doc/BRIEF.md
# Scanline Clock Filter with Line Interrupt Counter

This block derives one clean clock per video scanline from the pattern-table address bit A12. During sprite fetches A12 toggles every couple of memory reads. A plain edge detector would count each of those toggles. Instead, the block qualifies each rising edge of A12 with a hold-off timer that is clocked by the CPU phase clock M2. A rise is counted only when the timer has run down to zero. Any sample of A12 high loads the timer again, so a burst of toggles yields a single count. An isolated rise that follows a long enough low period still counts.

A12 is first registered on M2, so a pulse that does not cover a clock edge cannot be seen. The single-cycle filtered pulse drives a small line counter. This counter loads from a programmable latch when it is zero or when a reload has been requested, and otherwise counts down. It raises a sticky interrupt when a count lands on zero while interrupts are enabled. The interrupt stays set until the CPU acknowledges it.

Top module: `a12_line_irq`

## Requirements
- R1: `line_tick_o` is a pulse one cycle wide. It is high in the cycle after the clock edge that first samples `a12_in` high, and it is never high in two consecutive cycles.
- R2: A rising edge of the sampled A12 produces a tick only when the hold-off timer is zero. After reset the timer is zero, so the first rise ticks.
- R3: When a tick is issued, the hold-off timer is loaded with HOLD (default 3).
- R4: While the sampled A12 is low and no tick is issued, the timer decrements by one per cycle down to zero. A rise after at least HOLD low samples ticks. A rise after fewer low samples is suppressed.
- R5: Every cycle in which the sampled A12 is high reloads the timer to HOLD. A long high period or a fast toggle burst therefore gives exactly one tick.
- R6: `a12_in` is sampled only at the rising clock edge. A high pulse that lies entirely between two edges causes no tick and leaves the count unchanged.
- R7: Two rises four cycles apart (high for 1 sample, then low for 3) both tick with the default HOLD.
- R8: On a tick, `line_count_o` loads `latch_din` as last written by `latch_we` in either of two cases: the count is zero, or `reload_req` was pulsed since the previous tick. Otherwise the count decrements by one. Without a tick, the count holds.
- R9: `irq_o` sets in the cycle after a tick that leaves the count at zero while `irq_enable` is 1. It stays set through further ticks until `irq_ack` is sampled high, which clears it in the following cycle.
- R10: With `irq_enable` at 0, a count landing on zero does not set `irq_o`.
- R11: Synchronous active-low reset clears the synchronizer, the hold-off timer, the count, the latch, the pending reload and `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_m2 | input | 1 | CPU phase clock M2; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| a12_in | input | 1 | Raw pattern-table address bit A12 |
| latch_we | input | 1 | Writes `latch_din` into the reload latch |
| latch_din | input | CNT_W | Reload value for the line counter |
| reload_req | input | 1 | Forces a reload from the latch on the next tick |
| irq_enable | input | 1 | Allows a zero count to set the interrupt |
| irq_ack | input | 1 | Clears the pending interrupt |
| line_tick_o | output | 1 | Filtered one-cycle scanline clock |
| line_count_o | output | CNT_W | Current line counter value |
| irq_o | output | 1 | Sticky line interrupt, active high |

## Verification
If the hold-off timer holds a wrong value, the error appears at `line_tick_o` within HOLD+1 cycles. A timer that is stale, or that is not reloaded while A12 is high, lets an extra tick through from a toggle burst or a 2-cycle low gap. A timer stuck non-zero swallows the tick of a rise that comes after a 3- or 4-cycle gap. A fault in the line counter or the reload flag is visible on `line_count_o` one cycle after the tick that uses it. A fault in the interrupt flag is visible on `irq_o` one cycle after the count reaches zero or after an acknowledge. The stimulus therefore checks the tick cycle by cycle through a toggle pattern with gaps of 2, 3 and 4 cycles, and reads the count and interrupt after every qualified pulse.

// File: rtl/a12f_pkg.sv
// Package: shared defaults and the sampled-A12 type used by the
// scanline clock filter. Assumes a single clock domain (M2).
package a12f_pkg;

    // Default hold-off length in M2 cycles
    localparam int unsigned HOLD_DEF   = 3;
    // Default line counter width
    localparam int unsigned CNT_W_DEF  = 8;
    // Default number of synchronizer flops on A12
    localparam int unsigned STAGES_DEF = 1;

    // Registered A12 level with the level of the cycle before
    typedef struct packed {
        logic level;   // A12 as sampled this cycle
        logic prev;    // A12 as sampled one cycle earlier
    } a12_sample_t;

endpackage

// File: rtl/a12f_sync.sv
// Module: a12f_sync
// Registers the raw A12 input through STAGES flops clocked by M2,
// then keeps one extra delayed copy so the consumer can see an edge.
// Assumes a12_in may change at any time; only edge samples matter.
module a12f_sync
    import a12f_pkg::*;
#(
    parameter int unsigned STAGES = STAGES_DEF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        a12_in,
    output a12_sample_t smp_o
);

    logic [STAGES-1:0] pipe;
    logic              last_q;

    // Synchronizer chain: shift the raw input in on each M2 edge
    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) pipe <= '0;
                else        pipe <= a12_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (!rst_n) pipe <= '0;
                else        pipe <= {pipe[STAGES-2:0], a12_in};
            end
        end
    endgenerate

    // Delayed copy of the synchronized level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= pipe[STAGES-1];
    end

    assign smp_o.level = pipe[STAGES-1];
    assign smp_o.prev  = last_q;

    // R6: the first flop holds exactly what was on the pin at the last edge
    p_sample_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (pipe[0] == $past(a12_in)));

    // R1: the delayed copy trails the level by one cycle
    p_prev_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (smp_o.prev == $past(smp_o.level)));

endmodule

// File: rtl/a12f_holdoff.sv
// Module: a12f_holdoff
// Counter-based monostable. A rising sampled A12 yields a one-cycle
// tick only when the hold-off timer is zero. Any high sample, and
// every tick, reloads the timer to HOLD. Otherwise the timer counts
// down once per M2 cycle. Assumes HOLD >= 1.
module a12f_holdoff
    import a12f_pkg::*;
#(
    parameter int unsigned HOLD = HOLD_DEF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  a12_sample_t smp_i,
    output logic        tick_o
);

    localparam int unsigned HW = $clog2(HOLD + 1);
    localparam logic [HW-1:0] HOLD_V = HW'(HOLD);

    logic [HW-1:0] timer_q;
    logic          rise;
    logic          idle;

    // Edge and idle detection on registered values only
    always_comb begin
        rise   = smp_i.level & ~smp_i.prev;
        idle   = (timer_q == '0);
        tick_o = rise & idle;
    end

    // Hold-off timer: reload on tick or high level, else count down
    always_ff @(posedge clk) begin
        if (!rst_n)                      timer_q <= '0;
        else if (tick_o || smp_i.level)  timer_q <= HOLD_V;
        else if (!idle)                  timer_q <= timer_q - HW'(1);
    end

    // R3: after a tick the timer holds the full hold-off value
    p_load_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (timer_q == HOLD_V));

    // R5: a high sample leaves the timer at its full value
    p_reload_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        smp_i.level |=> (timer_q == HOLD_V));

    // R4: with A12 low and no tick, a non-zero timer drops by one
    p_count_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_i.level && !tick_o && timer_q != '0) |=> (timer_q == $past(timer_q) - HW'(1)));

    // R2: a rise seen while the timer is busy must not tick
    p_busy_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (timer_q != '0) |-> !tick_o);

endmodule

// File: rtl/a12f_line_counter.sv
// Module: a12f_line_counter
// Down-counting line counter driven by the filtered tick. On a tick
// it loads the latch when empty or when a reload is pending, else it
// decrements. A tick leaving zero with enable set raises a sticky
// interrupt that only an acknowledge clears. Set wins over clear.
module a12f_line_counter #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             latch_we,
    input  logic [CNT_W-1:0] latch_din,
    input  logic             reload_req,
    input  logic             irq_enable,
    input  logic             irq_ack,
    output logic [CNT_W-1:0] count_o,
    output logic             irq_o
);

    logic [CNT_W-1:0] latch_q;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] count_nx;
    logic             pend_q;
    logic             irq_q;

    // Value the counter takes on the next tick
    always_comb begin
        if (count_q == '0 || pend_q) count_nx = latch_q;
        else                         count_nx = count_q - CNT_W'(1);
    end

    // Reload latch written by the CPU side
    always_ff @(posedge clk) begin
        if (!rst_n)        latch_q <= '0;
        else if (latch_we) latch_q <= latch_din;
    end

    // Pending reload: set by request, consumed by the next tick
    always_ff @(posedge clk) begin
        if (!rst_n)          pend_q <= 1'b0;
        else if (reload_req) pend_q <= 1'b1;
        else if (tick_i)     pend_q <= 1'b0;
    end

    // Line counter: advance only on a filtered tick
    always_ff @(posedge clk) begin
        if (!rst_n)      count_q <= '0;
        else if (tick_i) count_q <= count_nx;
    end

    // Sticky interrupt flag: set on zero with enable, cleared by ack
    always_ff @(posedge clk) begin
        if (!rst_n)                                       irq_q <= 1'b0;
        else if (tick_i && count_nx == '0 && irq_enable)  irq_q <= 1'b1;
        else if (irq_ack)                                 irq_q <= 1'b0;
    end

    assign count_o = count_q;
    assign irq_o   = irq_q;

    // R8: without a tick the count does not move
    p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> (count_q == $past(count_q)));

    // R8: a plain tick on a non-zero count with nothing pending decrements
    p_decrement_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && count_q != '0 && !pend_q) |=> (count_q == $past(count_q) - CNT_W'(1)));

    // R9: a pending interrupt survives until acknowledged
    p_irq_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !irq_ack) |=> irq_q);

    // R10: with interrupts disabled a clear flag stays clear
    p_irq_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_q && !irq_enable) |=> !irq_q);

endmodule

// File: rtl/a12_line_irq.sv
// Module: a12_line_irq (top)
// Scanline clock filter: synchronizes A12 on M2, qualifies rising
// edges with a hold-off monostable and drives a line counter with a
// sticky interrupt. Assumes clk_m2 is the only clock.
module a12_line_irq
    import a12f_pkg::*;
#(
    parameter int unsigned HOLD   = HOLD_DEF,
    parameter int unsigned CNT_W  = CNT_W_DEF,
    parameter int unsigned STAGES = STAGES_DEF
) (
    input  logic             clk_m2,
    input  logic             rst_n,
    input  logic             a12_in,
    input  logic             latch_we,
    input  logic [CNT_W-1:0] latch_din,
    input  logic             reload_req,
    input  logic             irq_enable,
    input  logic             irq_ack,
    output logic             line_tick_o,
    output logic [CNT_W-1:0] line_count_o,
    output logic             irq_o
);

    a12_sample_t smp;
    logic        tick;

    a12f_sync #(.STAGES(STAGES)) sync_i (
        .clk    (clk_m2),
        .rst_n  (rst_n),
        .a12_in (a12_in),
        .smp_o  (smp)
    );

    a12f_holdoff #(.HOLD(HOLD)) hold_i (
        .clk    (clk_m2),
        .rst_n  (rst_n),
        .smp_i  (smp),
        .tick_o (tick)
    );

    a12f_line_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk        (clk_m2),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .latch_we   (latch_we),
        .latch_din  (latch_din),
        .reload_req (reload_req),
        .irq_enable (irq_enable),
        .irq_ack    (irq_ack),
        .count_o    (line_count_o),
        .irq_o      (irq_o)
    );

    assign line_tick_o = tick;

    // R1: the filtered clock is never wider than one cycle
    p_single_tick_r1: assert property (@(posedge clk_m2) disable iff (!rst_n)
        line_tick_o |=> !line_tick_o);

endmodule

// File: tb/a12_line_irq_tb.sv
// Bench for a12_line_irq: cycle table for the hold-off filter, then
// directed tests for the counter, interrupt, glitches and reset.
module a12_line_irq_tb_top;

    localparam int CNT_W = 8;
    localparam int NVEC  = 24;
    // Each entry: {a12 driven this step, expected tick after the edge}
    localparam logic [1:0] VEC [NVEC] = '{
        2'b00, 2'b11, 2'b10, 2'b00, 2'b00, 2'b00, 2'b11, 2'b00,
        2'b00, 2'b00, 2'b11, 2'b00, 2'b10, 2'b00, 2'b10, 2'b00,
        2'b00, 2'b10, 2'b00, 2'b00, 2'b00, 2'b00, 2'b11, 2'b00
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             a12_in = 1'b0;
    logic             latch_we = 1'b0;
    logic [CNT_W-1:0] latch_din = '0;
    logic             reload_req = 1'b0;
    logic             irq_enable = 1'b0;
    logic             irq_ack = 1'b0;
    logic             line_tick_o;
    logic [CNT_W-1:0] line_count_o;
    logic             irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    a12_line_irq dut_i (
        .clk_m2       (clk),
        .rst_n        (rst_n),
        .a12_in       (a12_in),
        .latch_we     (latch_we),
        .latch_din    (latch_din),
        .reload_req   (reload_req),
        .irq_enable   (irq_enable),
        .irq_ack      (irq_ack),
        .line_tick_o  (line_tick_o),
        .line_count_o (line_count_o),
        .irq_o        (irq_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Drive A12 for one cycle, then wait just past the sampling edge
    task automatic step(input logic v);
        @(negedge clk);
        a12_in = v;
        @(posedge clk);
        #1;
    endtask

    // Four low samples, one high (tick expected as given), one low
    task automatic pulse(input int exp_tick, input string req);
        repeat (4) step(1'b0);
        step(1'b1);
        chk(req, int'(line_tick_o), exp_tick);
        step(1'b0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: got 0 expected 1 (bench finished)");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1;
        // R11: reset state
        chk("R11 tick", int'(line_tick_o), 0);
        chk("R11 count", int'(line_count_o), 0);
        chk("R11 irq", int'(irq_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        latch_we = 1'b1;
        latch_din = 8'd2;
        @(negedge clk);
        latch_we = 1'b0;

        // R1 R2 R3 R4 R5 R7: cycle table of the hold-off filter
        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][1]);
            chk($sformatf("R4 table step %0d tick", i), int'(line_tick_o), int'(VEC[i][0]));
        end
        // four ticks: load 2, then 1, then 0 (masked, R10), then reload 2
        chk("R8 count after table", int'(line_count_o), 2);
        chk("R10 irq masked in table", int'(irq_o), 0);

        // R9: interrupt set at zero with enable, sticky, cleared by ack
        irq_enable = 1'b1;
        pulse(1, "R9 tick a");
        chk("R8 count 1", int'(line_count_o), 1);
        chk("R9 irq still clear", int'(irq_o), 0);
        pulse(1, "R9 tick b");
        chk("R9 count 0", int'(line_count_o), 0);
        chk("R9 irq set", int'(irq_o), 1);
        pulse(1, "R9 tick c");
        chk("R8 reload from zero", int'(line_count_o), 2);
        chk("R9 irq sticky", int'(irq_o), 1);
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        #1;
        chk("R9 irq acked", int'(irq_o), 0);

        // R8: pending reload beats decrement on a non-zero count
        @(negedge clk);
        reload_req = 1'b1;
        latch_we = 1'b1;
        latch_din = 8'd5;
        @(negedge clk);
        reload_req = 1'b0;
        latch_we = 1'b0;
        chk("R8 no tick, count held", int'(line_count_o), 2);
        pulse(1, "R8 tick reload");
        chk("R8 forced reload", int'(line_count_o), 5);
        pulse(1, "R8 tick dec");
        chk("R8 decrement", int'(line_count_o), 4);

        // R10: count reaches zero with interrupts disabled
        irq_enable = 1'b0;
        repeat (4) pulse(1, "R10 tick");
        chk("R10 count zero", int'(line_count_o), 0);
        chk("R10 irq stays clear", int'(irq_o), 0);

        // R5: long high gives one tick, short gap after it is suppressed
        repeat (4) step(1'b0);
        step(1'b1);
        chk("R5 first high ticks", int'(line_tick_o), 1);
        for (int k = 0; k < 9; k++) begin
            step(1'b1);
            chk("R5 held high no tick", int'(line_tick_o), 0);
        end
        step(1'b0);
        step(1'b0);
        step(1'b1);
        chk("R5 rise after 2 low blocked", int'(line_tick_o), 0);
        step(1'b0);
        chk("R5 only one tick counted", int'(line_count_o), 5);

        // R6: a glitch between edges is never sampled
        repeat (5) step(1'b0);
        @(posedge clk);
        #1 a12_in = 1'b1;
        #1 a12_in = 1'b0;
        step(1'b0);
        chk("R6 glitch no tick", int'(line_tick_o), 0);
        step(1'b0);
        chk("R6 glitch no tick b", int'(line_tick_o), 0);
        chk("R6 count unchanged", int'(line_count_o), 5);

        // R11: mid-run reset clears state; first rise after it ticks
        irq_enable = 1'b1;
        pulse(1, "R11 pre tick");
        @(negedge clk);
        rst_n = 1'b0;
        a12_in = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        a12_in = 1'b0;
        chk("R11 count cleared", int'(line_count_o), 0);
        chk("R11 irq cleared", int'(irq_o), 0);
        step(1'b1);
        chk("R2 first rise after reset", int'(line_tick_o), 1);
        step(1'b0);
        chk("R11 latch cleared", int'(line_count_o), 0);
        chk("R11 zero load sets irq", int'(irq_o), 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule